// File: doc/BRIEF.md
# Privilege-Gated Counter Register Bank

This block keeps the standard counters of a processor hart and serves them through a simple register port. A 64-bit cycle counter advances on every clock, a retired-instruction counter advances on each pulse from the pipeline, and a time counter advances on each tick from a timebase. The performance counters at indices 3 to 31 have no events of their own, so each of them reads the current cycle count.

The block also holds the current privilege level and two 32-bit read-permission masks: one set by machine software for supervisor code, and one set by supervisor software for user code. A read from the counter window is checked against the mask that belongs to the current level. A read that is refused returns zero and raises a flag in the same cycle, so the surrounding pipeline can raise a trap. Writes into the counter window are dropped. The permission masks and the privilege register are written and read through the same port.

Top module: `perfctr_csr_bank`

## Requirements
- R1: After reset the privilege register holds machine level (code 3), and both permission masks hold 0x7.
- R2: The cycle counter rises by exactly one on every clock after reset.
- R3: The retired-instruction counter rises by one for each clock on which `instret_pulse` is high, and the time counter rises by one for each clock on which `time_tick` is high.
- R4: A permitted read of counter index 3 to 31 returns the current cycle count.
- R5: At machine level every counter read is permitted, whatever the masks hold.
- R6: At supervisor level (code 1) a read of counter index n is permitted only when bit n of the machine-set mask (address 0x306) is 1.
- R7: At user level (code 0) a read of counter index n is permitted only when bit n of the supervisor-set mask (address 0x106) is 1.
- R8: A refused read returns zero data and raises `csr_denied` in the same cycle; `csr_denied` is low whenever `csr_rd` is low.
- R9: A write to any address from 0xC00 to 0xC1F leaves every counter unchanged. Counter index n sits at address 0xC00+n (0 cycle, 1 time, 2 retired instructions, 3..31 performance counters).
- R10: The privilege register at address 0x7C0 takes the codes 0, 1 and 3 from the low two bits of a write; a write of code 2 leaves it unchanged.
- R11: Both permission masks take the low 32 bits of a write one clock later, and all three control registers read back their value, zero-extended, without raising `csr_denied`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_addr | input | 12 | Register address |
| csr_rd | input | 1 | Read strobe; data is returned combinationally |
| csr_wr | input | 1 | Write strobe; takes effect at the next clock edge |
| csr_wdata | input | 64 | Write data |
| instret_pulse | input | 1 | One retired instruction on this clock |
| time_tick | input | 1 | One timebase tick on this clock |
| csr_rdata | output | 64 | Read data |
| csr_denied | output | 1 | Read refused by the permission check |

## Verification
The checker follows every cycle for the counter arithmetic, the legality of the privilege code, the reset values, zero data under a refusal, the absence of refusal without a read, and the rule that machine level is never refused. Which mask governs which level, the bit position each index maps to, the mirroring of the cycle count by the performance counters and the dropping of writes into the counter window are shown by the bench's table walk and directed scenarios, which compare read data against counts kept by the bench.

// File: rtl/perfctr_pkg.sv
// Package: shared types and address map for the counter register bank.
// Assumes a 12-bit register address space with the counter window aligned
// to a 32-entry boundary.
package perfctr_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    localparam int ADDR_W       = 12;
    localparam int NUM_CNT      = 32;
    localparam int IDX_W        = $clog2(NUM_CNT);

    localparam logic [ADDR_W-1:0] ADDR_CNT_BASE = 12'hC00;
    localparam logic [ADDR_W-1:0] ADDR_MEN      = 12'h306;
    localparam logic [ADDR_W-1:0] ADDR_SEN      = 12'h106;
    localparam logic [ADDR_W-1:0] ADDR_PRIV     = 12'h7C0;

    localparam logic [NUM_CNT-1:0] EN_RESET = 32'h0000_0007;

    localparam int IDX_CYCLE   = 0;
    localparam int IDX_TIME    = 1;
    localparam int IDX_INSTRET = 2;

endpackage

// File: rtl/perfctr_counters.sv
// Module: the three counting registers (cycle, time, retired instructions).
// Assumes event inputs are synchronous single-cycle strobes; counters wrap.
module perfctr_counters #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instret_pulse,
    input  logic             time_tick,
    output logic [CNT_W-1:0] cycle_q,
    output logic [CNT_W-1:0] instret_q,
    output logic [CNT_W-1:0] time_q
);

    // Cycle counter: advances on every clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cycle_q <= '0;
        else        cycle_q <= cycle_q + 1'b1;
    end

    // Retired-instruction counter: advances on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)             instret_q <= '0;
        else if (instret_pulse) instret_q <= instret_q + 1'b1;
    end

    // Time counter: advances on each timebase tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         time_q <= '0;
        else if (time_tick) time_q <= time_q + 1'b1;
    end

endmodule

// File: rtl/perfctr_ctrl_regs.sv
// Module: privilege register and the two read-permission masks.
// Assumes write strobes are already decoded by address; a reserved
// privilege code is dropped so the register only ever holds a legal level.
module perfctr_ctrl_regs
    import perfctr_pkg::*;
#(
    parameter int N = NUM_CNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_priv,
    input  logic         wr_men,
    input  logic         wr_sen,
    input  logic [63:0]  wdata,
    output priv_e        priv_q,
    output logic [N-1:0] men_q,
    output logic [N-1:0] sen_q
);

    priv_e priv_in;

    // Cast the low two write bits into a privilege code.
    always_comb priv_in = priv_e'(wdata[1:0]);

    // Privilege register: machine level on reset, reserved code ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  priv_q <= PRIV_MACH;
        else if (wr_priv && (priv_in != PRIV_RSVD))  priv_q <= priv_in;
    end

    // Machine-set mask governing supervisor reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      men_q <= EN_RESET[N-1:0];
        else if (wr_men) men_q <= wdata[N-1:0];
    end

    // Supervisor-set mask governing user reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      sen_q <= EN_RESET[N-1:0];
        else if (wr_sen) sen_q <= wdata[N-1:0];
    end

endmodule

// File: rtl/perfctr_gate.sv
// Module: read-permission decision for one counter index.
// Assumes priv never holds the reserved code. Purely combinational.
module perfctr_gate
    import perfctr_pkg::*;
#(
    parameter int N   = NUM_CNT,
    parameter int IW  = $clog2(N)
) (
    input  priv_e         priv,
    input  logic [N-1:0]  men,
    input  logic [N-1:0]  sen,
    input  logic [IW-1:0] idx,
    output logic          allow
);

    // Choose the mask owned by the level above the current one.
    always_comb begin
        unique case (priv)
            PRIV_MACH:  allow = 1'b1;
            PRIV_SUPER: allow = men[idx];
            PRIV_USER:  allow = sen[idx];
            default:    allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/perfctr_csr_bank.sv
// Module: top of the counter register bank. Decodes the register port,
// routes counter values through a per-index source table, applies the
// permission check and drops writes into the counter window.
// Assumes one access per cycle; read data is combinational.
module perfctr_csr_bank
    import perfctr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_rd,
    input  logic              csr_wr,
    input  logic [63:0]       csr_wdata,
    input  logic              instret_pulse,
    input  logic              time_tick,
    output logic [63:0]       csr_rdata,
    output logic              csr_denied
);

    localparam int WIN_LSB = IDX_W;

    logic [CNT_W-1:0] cycle_q, instret_q, time_q;
    priv_e            priv_q;
    logic [NUM_CNT-1:0] men_q, sen_q;
    logic [CNT_W-1:0] src [NUM_CNT];
    logic             in_win, allow;
    logic [IDX_W-1:0] idx;
    logic             hit_priv, hit_men, hit_sen;

    perfctr_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .instret_pulse(instret_pulse), .time_tick(time_tick),
        .cycle_q(cycle_q), .instret_q(instret_q), .time_q(time_q)
    );

    // Address decode for the window and the control registers.
    always_comb begin
        in_win   = (csr_addr[ADDR_W-1:WIN_LSB] == ADDR_CNT_BASE[ADDR_W-1:WIN_LSB]);
        idx      = csr_addr[IDX_W-1:0];
        hit_priv = (csr_addr == ADDR_PRIV);
        hit_men  = (csr_addr == ADDR_MEN);
        hit_sen  = (csr_addr == ADDR_SEN);
    end

    // Window writes never reach a register; only control addresses are written.
    perfctr_ctrl_regs #(.N(NUM_CNT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_priv(csr_wr && hit_priv),
        .wr_men(csr_wr && hit_men),
        .wr_sen(csr_wr && hit_sen),
        .wdata(csr_wdata),
        .priv_q(priv_q), .men_q(men_q), .sen_q(sen_q)
    );

    // Source table: fixed counters at low indices, cycle mirrors above.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_src
        if (g == IDX_TIME) begin : g_time
            assign src[g] = time_q;
        end else if (g == IDX_INSTRET) begin : g_inst
            assign src[g] = instret_q;
        end else begin : g_cyc
            assign src[g] = cycle_q;
        end
    end

    perfctr_gate #(.N(NUM_CNT), .IW(IDX_W)) u_gate (
        .priv(priv_q), .men(men_q), .sen(sen_q), .idx(idx), .allow(allow)
    );

    // Read mux: counter window gated, control registers plain.
    always_comb begin
        csr_rdata  = '0;
        csr_denied = 1'b0;
        if (csr_rd) begin
            if (in_win) begin
                if (allow) csr_rdata = 64'(src[idx]);
                else       csr_denied = 1'b1;
            end else if (hit_priv) begin
                csr_rdata = 64'(priv_q);
            end else if (hit_men) begin
                csr_rdata = 64'(men_q);
            end else if (hit_sen) begin
                csr_rdata = 64'(sen_q);
            end
        end
    end

endmodule

// File: rtl/perfctr_csr_bank_chk.sv
// Checker: cycle-by-cycle properties of the counter register bank,
// attached to every instance of the top by the bind below.
module perfctr_csr_bank_chk
    import perfctr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_rd,
    input logic [63:0]        csr_rdata,
    input logic               csr_denied,
    input logic               instret_pulse,
    input logic               time_tick,
    input logic [CNT_W-1:0]   cycle_q,
    input logic [CNT_W-1:0]   instret_q,
    input logic [CNT_W-1:0]   time_q,
    input logic [1:0]         priv_q,
    input logic [NUM_CNT-1:0] men_q,
    input logic [NUM_CNT-1:0] sen_q
);

    a_r1_reset_values: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (priv_q == 2'd3 && men_q == 32'h7 && sen_q == 32'h7))
        else $error("R1 reset values");

    a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cycle_q == $past(cycle_q) + 1'b1)
        else $error("R2 cycle step");

    a_r3_instret_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> instret_q == $past(instret_q) + CNT_W'($past(instret_pulse)))
        else $error("R3 instret step");

    a_r3_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> time_q == $past(time_q) + CNT_W'($past(time_tick)))
        else $error("R3 time step");

    a_r5_machine_open: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_q == 2'd3) |-> !csr_denied)
        else $error("R5 machine refused");

    a_r8_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_denied |-> csr_rdata == 64'd0)
        else $error("R8 data under refusal");

    a_r8_denied_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd |-> !csr_denied)
        else $error("R8 refusal without read");

    a_r10_priv_legal: assert property (@(posedge clk) disable iff (!rst_n)
        priv_q != 2'd2)
        else $error("R10 reserved level held");

endmodule

bind perfctr_csr_bank perfctr_csr_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
    .csr_denied(csr_denied), .instret_pulse(instret_pulse), .time_tick(time_tick),
    .cycle_q(cycle_q), .instret_q(instret_q), .time_q(time_q),
    .priv_q(priv_q), .men_q(men_q), .sen_q(sen_q)
);

// File: tb/perfctr_csr_bank_tb.sv
`timescale 1ns/1ps
module perfctr_csr_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_rd = 1'b0;
    logic        csr_wr = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic        instret_pulse = 1'b0;
    logic        time_tick = 1'b0;
    logic [63:0] csr_rdata;
    logic        csr_denied;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    longint n_inst = 0;
    longint n_tick = 0;

    always #4 clk = ~clk;

    perfctr_csr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .instret_pulse(instret_pulse),
        .time_tick(time_tick), .csr_rdata(csr_rdata), .csr_denied(csr_denied)
    );

    // Vector: priv[71:70] men[69:38] sen[37:6] idx[5:1] expect_denied[0]
    localparam int NV = 10;
    localparam logic [71:0] VEC [NV] = '{
        {2'd3, 32'h0000_0000, 32'h0000_0000, 5'd5,  1'b0},
        {2'd1, 32'h0000_0007, 32'h0000_0000, 5'd1,  1'b0},
        {2'd1, 32'h0000_0007, 32'hFFFF_FFFF, 5'd3,  1'b1},
        {2'd1, 32'h8000_0000, 32'h0000_0000, 5'd31, 1'b0},
        {2'd1, 32'h8000_0000, 32'hFFFF_FFFF, 5'd30, 1'b1},
        {2'd0, 32'hFFFF_FFFF, 32'h0000_0000, 5'd0,  1'b1},
        {2'd0, 32'h0000_0000, 32'h0000_0004, 5'd2,  1'b0},
        {2'd0, 32'h0000_0000, 32'h0000_0004, 5'd1,  1'b1},
        {2'd3, 32'h0000_0000, 32'h0000_0000, 5'd31, 1'b0},
        {2'd0, 32'h0000_0000, 32'h0000_0010, 5'd4,  1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wr = 1'b1; csr_rd = 1'b0;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    // Read on the current low phase; data is combinational.
    task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic den);
        csr_addr = a; csr_rd = 1'b1;
        #1;
        d = csr_rdata; den = csr_denied;
        csr_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] d, d2;
        logic den;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(12'h7C0, d, den); check("R1 priv", d, 64'd3);
        rd(12'h306, d, den); check("R1 machine mask", d, 64'h7);
        rd(12'h106, d, den); check("R1 super mask", d, 64'h7);
        rd(12'hC02, d, den); check("R1 instret zero", d, 64'd0);

        // R3: instret pulses and time ticks
        @(negedge clk); instret_pulse = 1'b1;
        repeat (5) @(negedge clk);
        instret_pulse = 1'b0; time_tick = 1'b1;
        repeat (3) @(negedge clk);
        time_tick = 1'b0;
        n_inst = 5; n_tick = 3;
        rd(12'hC02, d, den); check("R3 instret count", d, 64'(n_inst));
        rd(12'hC01, d, den); check("R3 time count", d, 64'(n_tick));

        // R2: cycle advances one per clock
        rd(12'hC00, d, den);
        repeat (7) @(negedge clk);
        rd(12'hC00, d2, den); check("R2 cycle delta", d2 - d, 64'd7);

        // R4: performance counters mirror the cycle count
        rd(12'hC00, d, den);
        @(negedge clk);
        rd(12'hC11, d2, den); check("R4 hpm17 mirror", d2, d + 64'd1);
        @(negedge clk);
        rd(12'hC1F, d2, den); check("R4 hpm31 mirror", d2, d + 64'd2);

        // R9: writes into the counter window are dropped
        wr(12'hC02, 64'hDEAD);
        wr(12'hC01, 64'h0);
        rd(12'hC02, d, den); check("R9 instret unchanged", d, 64'(n_inst));
        rd(12'hC01, d, den); check("R9 time unchanged", d, 64'(n_tick));
        rd(12'hC00, d, den);
        wr(12'hC00, 64'd0);
        rd(12'hC00, d2, den); check("R9 cycle not cleared", d2 - d, 64'd2);

        // R5 R6 R7 R8 R11: table walk over levels, masks and indices
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  pv;
            logic [31:0] me, se;
            logic [4:0]  ix;
            logic        ed;
            {pv, me, se, ix, ed} = VEC[i];
            wr(12'h7C0, 64'd3);
            wr(12'h306, {32'hFFFF_FFFF, me});
            wr(12'h106, {32'hFFFF_FFFF, se});
            rd(12'h306, d, den); check("R11 machine mask readback", d, {32'd0, me});
            rd(12'h106, d, den); check("R11 super mask readback", d, {32'd0, se});
            wr(12'h7C0, {62'd0, pv});
            rd({7'h60, ix}, d, den);
            check(pv == 2'd3 ? "R5 machine read" : (pv == 2'd1 ? "R6 super gate" : "R7 user gate"),
                  {63'd0, den}, {63'd0, ed});
            if (ed)
                check("R8 refused data zero", d, 64'd0);
            else if (ix == 5'd1)
                check("R6 time data", d, 64'(n_tick));
            else if (ix == 5'd2)
                check("R7 instret data", d, 64'(n_inst));
            else
                check("R4 cycle-mirror nonzero", {63'd0, d != 0}, 64'd1);
        end

        // R8: no refusal flag when the strobe is low
        wr(12'h7C0, 64'd3);
        wr(12'h106, 64'd0);
        wr(12'h7C0, 64'd0);
        csr_addr = 12'hC00; #1;
        check("R8 flag low without read", {63'd0, csr_denied}, 64'd0);
        rd(12'hC00, d, den); check("R8 flag with read", {63'd0, den}, 64'd1);

        // R10: reserved level code is ignored, legal codes taken
        wr(12'h7C0, 64'd1);
        wr(12'h7C0, 64'd2);
        rd(12'h7C0, d, den); check("R10 reserved ignored", d, 64'd1);
        check("R11 control read not refused", {63'd0, den}, 64'd0);
        wr(12'h7C0, 64'hFFFF_FFFF_FFFF_FFF0);
        rd(12'h7C0, d, den); check("R10 user code taken", d, 64'd0);

        finish_run();
    end

endmodule